// File: doc/BRIEF.md
# GPIO Bank with Edge Interrupts

This block is a bank of general-purpose pins controlled through a plain 32-bit register bus. The bus has a write strobe, a read strobe, a word address, write data and read data. Every pin has four control bits: a data bit, a direction bit, a pull-off bit and an alternate-function bit. The data and direction registers each have two write-only aliases. One sets bits where the written word holds ones. The other clears bits where the written word holds ones. Software can therefore change a single pin without a read-modify-write sequence.

The data bit has two uses. On an output pin it sets the level the pin drives. On an input pin with pulls enabled it selects the pull-up (1) or the pull-down (0).

Incoming pin levels pass through a synchronizer chain. Each pin can flag a rising edge, a falling edge, or either edge. A flagged edge is latched in a status register, which software clears by writing ones to a separate clear word. The single `irq` output is high while any status bit is set.

Register decode is built as a small named selector. The word address maps to one of thirteen selector values:

- `SEL_DATA`, `SEL_DATA_SET`, `SEL_DATA_CLR`
- `SEL_PULL_OFF`
- `SEL_DIR`, `SEL_DIR_SET`, `SEL_DIR_CLR`
- `SEL_ALT`
- `SEL_RISE_MASK`, `SEL_FALL_MASK`
- `SEL_STATUS`, `SEL_STATUS_CLR`
- `SEL_NONE`, for every unmapped word

The block holds no sequencing state. Each bus cycle acts on the selector chosen by the address in that cycle.

Top module: `gpio_edge_bank`

## Requirements
- R1: After reset, the following are all 0: data, direction, pull-off, alternate-function, both edge masks and status. As a result, `pin_out`, `pin_oe`, `alt_sel`, `pull_up_en` and `irq` are all zero, and `pull_dn_en` is all ones.
- R2: Writes to the data register behave as follows. A write to word 0 (byte 0x00) loads the data register. A write to word 1 (byte 0x04) sets the data bits where the written word has ones. A write to word 2 (byte 0x08) clears the data bits where the written word has ones. All other data bits keep their value. `pin_out` shows the data register one clock after the write.
- R3: Writes to the direction register behave as follows. A write to word 4 (byte 0x10) loads it. Word 5 (byte 0x14) sets bits where the written word has ones. Word 6 (byte 0x18) clears bits where the written word has ones. Reading word 4 returns the register. A direction bit of 1 makes the pin an output, so `pin_oe` equals the direction bit, unless R6 applies.
- R4: Reading word 0 returns each pin's level taken from `pin_in` through a two-flop synchronizer. A stable new level is readable from the second clock edge after it appears.
- R5: The pull-off register sits at word 3 (byte 0x0C) and is readable. The pull enables depend on the pin state:
  - On an input pin whose pull-off bit is 0, a data bit of 1 asserts `pull_up_en` and a data bit of 0 asserts `pull_dn_en`.
  - A pull-off bit of 1 turns both pulls off.
  - Both pulls are off on an output pin.
- R6: The alternate-function register sits at word 8 (byte 0x20) and is readable. A bit of 1 drives `alt_sel` high for that pin and forces its `pin_oe` to 0.
- R7: Edge detection uses two readable mask registers. Word 16 (byte 0x40) enables rising edges and word 17 (byte 0x44) enables falling edges. An enabled edge on the synchronized level sets the pin's bit in the status register, word 18 (byte 0x48), on the third clock edge after `pin_in` changes. Setting both mask bits flags either edge, and a disabled edge sets nothing.
- R8: Writing word 19 (byte 0x4C) clears the status bits where the written word has ones. Zero bits have no effect. Writes to the status word itself are ignored.
- R9: If a clear write and a new enabled edge hit the same pin in the same cycle, the status bit stays set.
- R10: `irq` is high exactly when at least one status bit is set.
- R11: The following all read as 0:
  - unmapped words;
  - the set/clear aliases and the clear word;
  - any read with `rd_en` low.
  Writes to unmapped words change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W (6) | Word address (byte offset / 4) |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data, combinational from address |
| pin_in | input | NUM_PINS (32) | Levels sensed at the pins |
| pin_out | output | NUM_PINS (32) | Output level per pin |
| pin_oe | output | NUM_PINS (32) | Output enable per pin |
| pull_up_en | output | NUM_PINS (32) | Pull-up enable per pin |
| pull_dn_en | output | NUM_PINS (32) | Pull-down enable per pin |
| alt_sel | output | NUM_PINS (32) | Hand pin to the alternate function |
| irq | output | 1 | Combined interrupt |

## Verification
The bench builds the block with `NUM_PINS` = 32 and `SYNC_DEPTH` = 2. A full word therefore maps onto pins, and pin 31 sits at the top bit of every register. The edge flag lands on the third clock after a pin change. With that fixed latency the bench can place a clear write in exactly the cycle where a new edge is detected. `ADDR_W` = 6 lets the bench reach unmapped words between and beyond the mapped ones.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int BUS_W = 32;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_DATA,
        SEL_DATA_SET,
        SEL_DATA_CLR,
        SEL_PULL_OFF,
        SEL_DIR,
        SEL_DIR_SET,
        SEL_DIR_CLR,
        SEL_ALT,
        SEL_RISE_MASK,
        SEL_FALL_MASK,
        SEL_STATUS,
        SEL_STATUS_CLR
    } reg_sel_e;

    // Word address (byte offset divided by four) to register selector
    function automatic reg_sel_e decode_word(input logic [7:0] word);
        reg_sel_e s;
        case (word)
            8'd0:    s = SEL_DATA;
            8'd1:    s = SEL_DATA_SET;
            8'd2:    s = SEL_DATA_CLR;
            8'd3:    s = SEL_PULL_OFF;
            8'd4:    s = SEL_DIR;
            8'd5:    s = SEL_DIR_SET;
            8'd6:    s = SEL_DIR_CLR;
            8'd8:    s = SEL_ALT;
            8'd16:   s = SEL_RISE_MASK;
            8'd17:   s = SEL_FALL_MASK;
            8'd18:   s = SEL_STATUS;
            8'd19:   s = SEL_STATUS_CLR;
            default: s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[0] <= '0;
                else        stage_q[0] <= async_in;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign sync_out = stage_q[DEPTH-1];

endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] level,
    input  logic [WIDTH-1:0] rise_mask,
    input  logic [WIDTH-1:0] fall_mask,
    input  logic [WIDTH-1:0] clr_strobe,
    output logic [WIDTH-1:0] status,
    output logic             irq
);

    logic [WIDTH-1:0] level_prev_q;
    logic [WIDTH-1:0] rise_seen;
    logic [WIDTH-1:0] fall_seen;
    logic [WIDTH-1:0] hit;
    logic [WIDTH-1:0] status_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) level_prev_q <= '0;
        else        level_prev_q <= level;
    end

    always_comb begin
        rise_seen = level & ~level_prev_q;
        fall_seen = ~level & level_prev_q;
        hit       = (rise_seen & rise_mask) | (fall_seen & fall_mask);
    end

    // A new edge has priority over a clear in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= (status_q & ~clr_strobe) | hit;
    end

    assign status = status_q;
    assign irq    = |status_q;

    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(status_q) & ~$past(clr_strobe)) & ~status_q) == '0)); // R8

    AST_NO_UNMASKED_SET: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_q & ~$past(status_q) & ~($past(rise_mask) | $past(fall_mask))) == '0)); // R7

    AST_EDGE_BEATS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_strobe & hit)) |=> ((status_q & $past(clr_strobe & hit)) == $past(clr_strobe & hit))); // R9

endmodule

// File: rtl/gpio_reg_file.sv
module gpio_reg_file
    import gpio_bank_pkg::*;
#(
    parameter int WIDTH  = 32,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BUS_W-1:0]  wr_data,
    output logic [BUS_W-1:0]  rd_data,
    input  logic [WIDTH-1:0]  pin_level,
    input  logic [WIDTH-1:0]  status,
    output logic [WIDTH-1:0]  data_q,
    output logic [WIDTH-1:0]  dir_q,
    output logic [WIDTH-1:0]  pull_off_q,
    output logic [WIDTH-1:0]  alt_q,
    output logic [WIDTH-1:0]  rise_mask_q,
    output logic [WIDTH-1:0]  fall_mask_q,
    output logic [WIDTH-1:0]  clr_strobe
);

    reg_sel_e         sel;
    logic [WIDTH-1:0] wbits;

    always_comb begin
        sel   = decode_word(8'(addr));
        wbits = wr_data[WIDTH-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q      <= '0;
            dir_q       <= '0;
            pull_off_q  <= '0;
            alt_q       <= '0;
            rise_mask_q <= '0;
            fall_mask_q <= '0;
        end else if (wr_en) begin
            unique case (sel)
                SEL_DATA:      data_q      <= wbits;
                SEL_DATA_SET:  data_q      <= data_q | wbits;
                SEL_DATA_CLR:  data_q      <= data_q & ~wbits;
                SEL_PULL_OFF:  pull_off_q  <= wbits;
                SEL_DIR:       dir_q       <= wbits;
                SEL_DIR_SET:   dir_q       <= dir_q | wbits;
                SEL_DIR_CLR:   dir_q       <= dir_q & ~wbits;
                SEL_ALT:       alt_q       <= wbits;
                SEL_RISE_MASK: rise_mask_q <= wbits;
                SEL_FALL_MASK: fall_mask_q <= wbits;
                default: ;
            endcase
        end
    end

    assign clr_strobe = (wr_en && sel == SEL_STATUS_CLR) ? wbits : '0;

    always_comb begin
        rd_data = '0;
        if (rd_en) begin
            unique case (sel)
                SEL_DATA:      rd_data[WIDTH-1:0] = pin_level;
                SEL_PULL_OFF:  rd_data[WIDTH-1:0] = pull_off_q;
                SEL_DIR:       rd_data[WIDTH-1:0] = dir_q;
                SEL_ALT:       rd_data[WIDTH-1:0] = alt_q;
                SEL_RISE_MASK: rd_data[WIDTH-1:0] = rise_mask_q;
                SEL_FALL_MASK: rd_data[WIDTH-1:0] = fall_mask_q;
                SEL_STATUS:    rd_data[WIDTH-1:0] = status;
                default:       rd_data = '0;
            endcase
        end
    end

    AST_DATA_SET_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_DATA_SET) |=>
        (((data_q & $past(wbits)) == $past(wbits)) &&
         ((data_q & ~$past(wbits)) == ($past(data_q) & ~$past(wbits))))); // R2

    AST_DATA_CLR_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_DATA_CLR) |=>
        (((data_q & $past(wbits)) == '0) &&
         ((data_q & ~$past(wbits)) == ($past(data_q) & ~$past(wbits))))); // R2

    AST_DIR_SET_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_DIR_SET) |=> ((dir_q & $past(wbits)) == $past(wbits))); // R3

    AST_UNMAPPED_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_NONE) |=> ($stable(data_q) && $stable(dir_q) && $stable(alt_q)
                                        && $stable(pull_off_q))); // R11

    AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> (rd_data == '0)); // R11

endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] data_q,
    input  logic [WIDTH-1:0] dir_q,
    input  logic [WIDTH-1:0] pull_off_q,
    input  logic [WIDTH-1:0] alt_q,
    output logic [WIDTH-1:0] pin_out,
    output logic [WIDTH-1:0] pin_oe,
    output logic [WIDTH-1:0] pull_up_en,
    output logic [WIDTH-1:0] pull_dn_en,
    output logic [WIDTH-1:0] alt_sel
);

    for (genvar p = 0; p < WIDTH; p++) begin : g_pin
        logic pull_on;
        assign pull_on       = ~dir_q[p] & ~pull_off_q[p];
        assign pin_out[p]    = data_q[p];
        assign pin_oe[p]     = dir_q[p] & ~alt_q[p];
        assign pull_up_en[p] = pull_on & data_q[p];
        assign pull_dn_en[p] = pull_on & ~data_q[p];
        assign alt_sel[p]    = alt_q[p];
    end

    AST_PULLS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (pull_up_en & pull_dn_en) == '0); // R5

    AST_NO_PULL_ON_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_q & (pull_up_en | pull_dn_en)) == '0); // R5

    AST_ALT_BLOCKS_OE: assert property (@(posedge clk) disable iff (!rst_n)
        (alt_sel & pin_oe) == '0); // R6

endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PINS   = 32,
    parameter int ADDR_W     = 6,
    parameter int SYNC_DEPTH = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [BUS_W-1:0]    wr_data,
    output logic [BUS_W-1:0]    rd_data,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic [NUM_PINS-1:0] pull_up_en,
    output logic [NUM_PINS-1:0] pull_dn_en,
    output logic [NUM_PINS-1:0] alt_sel,
    output logic                irq
);

    logic [NUM_PINS-1:0] level_sync;
    logic [NUM_PINS-1:0] status;
    logic [NUM_PINS-1:0] data_q;
    logic [NUM_PINS-1:0] dir_q;
    logic [NUM_PINS-1:0] pull_off_q;
    logic [NUM_PINS-1:0] alt_q;
    logic [NUM_PINS-1:0] rise_mask_q;
    logic [NUM_PINS-1:0] fall_mask_q;
    logic [NUM_PINS-1:0] clr_strobe;

    gpio_sync #(.WIDTH(NUM_PINS), .DEPTH(SYNC_DEPTH)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (level_sync)
    );

    gpio_reg_file #(.WIDTH(NUM_PINS), .ADDR_W(ADDR_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .rd_en       (rd_en),
        .addr        (addr),
        .wr_data     (wr_data),
        .rd_data     (rd_data),
        .pin_level   (level_sync),
        .status      (status),
        .data_q      (data_q),
        .dir_q       (dir_q),
        .pull_off_q  (pull_off_q),
        .alt_q       (alt_q),
        .rise_mask_q (rise_mask_q),
        .fall_mask_q (fall_mask_q),
        .clr_strobe  (clr_strobe)
    );

    gpio_edge_irq #(.WIDTH(NUM_PINS)) u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .level      (level_sync),
        .rise_mask  (rise_mask_q),
        .fall_mask  (fall_mask_q),
        .clr_strobe (clr_strobe),
        .status     (status),
        .irq        (irq)
    );

    gpio_pad_ctrl #(.WIDTH(NUM_PINS)) u_pad (
        .clk        (clk),
        .rst_n      (rst_n),
        .data_q     (data_q),
        .dir_q      (dir_q),
        .pull_off_q (pull_off_q),
        .alt_q      (alt_q),
        .pin_out    (pin_out),
        .pin_oe     (pin_oe),
        .pull_up_en (pull_up_en),
        .pull_dn_en (pull_dn_en),
        .alt_sel    (alt_sel)
    );

    AST_IRQ_TRACKS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(status) == '0 && status != '0)); // R10

endmodule

// File: tb/tb_gpio_edge_bank.sv
`timescale 1ns/1ps
module tb_gpio_edge_bank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out, pin_oe, pull_up_en, pull_dn_en, alt_sel;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [31:0] m_data = '0, m_dir = '0, m_poff = '0, m_alt = '0;
    logic [31:0] m_rm = '0, m_fm = '0, m_st = '0, m_pins = '0;

    always #2 clk = ~clk;

    gpio_edge_bank dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .pin_in(pin_in), .pin_out(pin_out),
        .pin_oe(pin_oe), .pull_up_en(pull_up_en), .pull_dn_en(pull_dn_en),
        .alt_sel(alt_sel), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(input logic [5:0] a);
        case (a)
            6'd0:  return m_pins;
            6'd3:  return m_poff;
            6'd4:  return m_dir;
            6'd8:  return m_alt;
            6'd16: return m_rm;
            6'd17: return m_fm;
            6'd18: return m_st;
            default: return 32'h0;
        endcase
    endfunction

    task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
        case (a)
            6'd0:  m_data = d;
            6'd1:  m_data = m_data | d;
            6'd2:  m_data = m_data & ~d;
            6'd3:  m_poff = d;
            6'd4:  m_dir  = d;
            6'd5:  m_dir  = m_dir | d;
            6'd6:  m_dir  = m_dir & ~d;
            6'd8:  m_alt  = d;
            6'd16: m_rm   = d;
            6'd17: m_fm   = d;
            6'd19: m_st   = m_st & ~d;
            default: ;
        endcase
    endtask

    task automatic bus_read_check(input string req, input logic [5:0] a);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1;
        check(req, rd_data, exp_read(a));
        rd_en = 1'b0;
    endtask

    task automatic check_pads(input string req);
        check({req, " pin_out"}, pin_out, m_data);
        check({req, " pin_oe"},  pin_oe, m_dir & ~m_alt);
        check({req, " pull_up"}, pull_up_en, ~m_dir & ~m_poff & m_data);
        check({req, " pull_dn"}, pull_dn_en, ~m_dir & ~m_poff & ~m_data);
        check({req, " alt_sel"}, alt_sel, m_alt);
    endtask

    task automatic pin_step(input logic [31:0] v);
        @(negedge clk);
        pin_in = v;
        m_st = m_st | (v & ~m_pins & m_rm) | (~v & m_pins & m_fm);
        m_pins = v;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        logic [5:0] cfg_words [15];
        int unused_seed;
        cfg_words = '{6'd0, 6'd1, 6'd2, 6'd3, 6'd4, 6'd5, 6'd6, 6'd8,
                      6'd16, 6'd17, 6'd7, 6'd9, 6'd12, 6'd20, 6'd18};
        unused_seed = $urandom(32'h5EED_0042);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 pin_out", pin_out, 32'h0);
        check("R1 pin_oe", pin_oe, 32'h0);
        check("R1 alt_sel", alt_sel, 32'h0);
        check("R1 pull_up", pull_up_en, 32'h0);
        check("R1 pull_dn", pull_dn_en, 32'hFFFF_FFFF);
        check("R1 irq", {31'h0, irq}, 32'h0);
        bus_read_check("R1 status", 6'd18);
        bus_read_check("R1 dir", 6'd4);
        bus_read_check("R1 rise mask", 6'd16);

        // R2 data register and its aliases
        bus_write(6'd0, 32'hA5A5_0F0F);
        check("R2 data load", pin_out, 32'hA5A5_0F0F);
        bus_write(6'd1, 32'h8000_00F0);
        check("R2 data set", pin_out, 32'hA5A5_0FFF);
        bus_write(6'd2, 32'h0F00_0001);
        check("R2 data clear", pin_out, 32'hA0A5_0FFE);
        bus_write(6'd1, 32'h0);
        check("R2 set of zero", pin_out, 32'hA0A5_0FFE);

        // R3 direction register and its aliases
        bus_write(6'd4, 32'h0000_FF00);
        bus_write(6'd5, 32'h8000_0001);
        bus_write(6'd6, 32'h0000_0F00);
        bus_read_check("R3 dir readback", 6'd4);
        check("R3 oe", pin_oe, 32'h8000_F001);
        check_pads("R3");

        // R5 pulls on inputs, pull-off and outputs
        bus_write(6'd3, 32'h0000_FFFF);
        bus_read_check("R5 pull-off readback", 6'd3);
        check_pads("R5");

        // R6 alternate function gates output enables
        bus_write(6'd4, 32'hFFFF_FFFF);
        bus_write(6'd8, 32'hFF00_FF00);
        check("R6 oe gated", pin_oe, 32'h00FF_00FF);
        bus_read_check("R6 alt readback", 6'd8);
        check_pads("R6");

        // R11 unmapped words, aliases and idle reads
        bus_write(6'd7, 32'hFFFF_FFFF);
        bus_write(6'd9, 32'h0);
        bus_write(6'd63, 32'h1234_5678);
        check_pads("R11 unmapped writes");
        bus_read_check("R11 unmapped 7", 6'd7);
        bus_read_check("R11 data-set alias", 6'd1);
        bus_read_check("R11 dir-clear alias", 6'd6);
        bus_read_check("R11 clear word", 6'd19);
        bus_read_check("R11 dir after unmapped", 6'd4);
        @(negedge clk);
        rd_en = 1'b0; addr = 6'd4;
        #1 check("R11 read without rd_en", rd_data, 32'h0);

        // Random configuration traffic (R2 R3 R5 R6 R11)
        for (int i = 0; i < 80; i++) begin
            logic [5:0] a;
            a = cfg_words[$urandom_range(0, 14)];
            bus_write(a, $urandom());
            check_pads("R2/R3/R5/R6 random");
            if (i % 4 == 0)
                bus_read_check("R11 random readback", cfg_words[$urandom_range(0, 14)]);
        end

        // R4 synchronized pin levels; clear leftover status first
        bus_write(6'd16, 32'h0);
        bus_write(6'd17, 32'h0);
        bus_write(6'd19, 32'hFFFF_FFFF);
        for (int i = 0; i < 6; i++) begin
            pin_step($urandom());
            bus_read_check("R4 pin level", 6'd0);
        end
        bus_read_check("R4 no masks no status", 6'd18);

        // R4 timing: new level visible after two edges, not after one
        @(negedge clk);
        pin_in = ~m_pins;
        @(negedge clk);
        rd_en = 1'b1; addr = 6'd0;
        #1 check("R4 one edge old level", rd_data, m_pins);
        @(negedge clk);
        #1 check("R4 two edges new level", rd_data, ~m_pins);
        rd_en = 1'b0;
        m_pins = ~m_pins;
        repeat (3) @(negedge clk);

        // R7 R8 R10 edges with mixed masks
        bus_write(6'd16, 32'h00FF_00FF);
        bus_write(6'd17, 32'h00FF_FF00);
        for (int i = 0; i < 40; i++) begin
            pin_step($urandom());
            bus_read_check("R7 status", 6'd18);
            check("R10 irq", {31'h0, irq}, {31'h0, (m_st != 0)});
            if (i % 3 == 2) begin
                bus_write(6'd19, $urandom());
                bus_read_check("R8 clear", 6'd18);
            end
            if (i % 7 == 3) begin
                bus_write(6'd19, 32'h0);
                bus_write(6'd18, 32'h0);
                bus_read_check("R8 zero clear and status write ignored", 6'd18);
            end
        end
        bus_write(6'd19, 32'hFFFF_FFFF);
        check("R10 irq after full clear", {31'h0, irq}, 32'h0);

        // R7 disabled edge direction sets nothing
        bus_write(6'd16, 32'h0000_0001);
        bus_write(6'd17, 32'h0);
        pin_step(m_pins & ~32'h1);
        pin_step(m_pins & ~32'h1);
        bus_read_check("R7 masked falling edge", 6'd18);

        // R9 clear and new edge in the same cycle
        bus_write(6'd16, 32'h0000_0220);
        bus_write(6'd17, 32'h0);
        pin_step(32'h0);
        bus_write(6'd19, 32'hFFFF_FFFF);
        pin_step(32'h0000_0220);
        pin_step(32'h0);
        bus_read_check("R9 setup", 6'd18);
        @(negedge clk);
        pin_in = 32'h0000_0020;
        @(negedge clk);
        @(negedge clk);
        wr_en = 1'b1; addr = 6'd19; wr_data = 32'h0000_0220;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
        m_pins = 32'h0000_0020;
        m_st = 32'h0000_0020;
        repeat (2) @(negedge clk);
        bus_read_check("R9 edge wins over clear", 6'd18);
        check("R9 irq held", {31'h0, irq}, 32'h1);

        done = 1'b1;
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  %0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule